// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous static memory. Command, address, lane enables and burst order are all captured on the rising clock edge. Read data flows straight from the array to the output during the cycle after capture, with no output register in between.

Write data trails its command by one cycle. The data bus is therefore free in the same cycle slot for either direction. Reads and writes can alternate on every cycle with no idle cycle between them.

A two-bit beat counter steps through a four-word group, starting from a loaded base address. The step order is either wrapping increment or XOR. A sleep input halts every register and the array while keeping their contents, so work resumes exactly where it stopped.

Top module: `zsram_ft`

## Requirements
- R1: After synchronous reset, `rvalid_o` is 0 and `rdata_o` is all zeros. A continue command (`cmd_i`=2'b11) issued before any load behaves as a deselect.
- R2: A read load (`cmd_i`=2'b01) captured at edge k gives `rvalid_o`=1 and `rdata_o`=word[`addr_i`] during the cycle between edge k and edge k+1, provided `oe_i` is high.
- R3: A write load (`cmd_i`=2'b10) captured at edge k takes its data from `wdata_i` in the following cycle and stores it at edge k+1. Lanes are 9 bits wide when `DATA_W` is a multiple of 9 and 8 bits otherwise; lane i covers bits [i*LW +: LW]. Only lanes whose `byte_we_i` bit was 1 at edge k change. During that data cycle `rvalid_o`=0 and `rdata_o`=0.
- R4: A read issued on the cycle right after a write to the same address returns the newly written data. A write issued right after a read needs no idle cycle.
- R5: With `order_i`=0 at load time, beat n of a burst (n = 0 for the load, then 1, 2, 3 for each continue) addresses low bits (base+n) mod 4. The upper address bits stay those of the base.
- R6: With `order_i`=1 at load time, beat n addresses low bits base XOR n. The order is latched at load, so `order_i` is ignored on continue cycles.
- R7: A continue keeps the direction (read or write) of the last load and takes fresh `byte_we_i` each beat. The beat counter wraps, so the fifth beat returns to the base address.
- R8: A deselect (`cmd_i`=2'b00) makes the next cycle idle (`rvalid_o`=0, `rdata_o`=0) and cancels the burst, so a following continue also acts as a deselect.
- R9: While `oe_i` is low, `rdata_o` is all zeros. Other behaviour is unchanged: `rvalid_o` still reports the read.
- R10: While `sleep_i` is high, no command is captured and no write is stored. `rvalid_o` and `rdata_o` are 0. The pending operation, the burst position and the memory contents are kept, and they take effect once `sleep_i` returns low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Freeze all state; output idle |
| cmd_i | input | 2 | 00 deselect, 01 load read, 10 load write, 11 continue |
| addr_i | input | ADDR_W | Word address for load commands |
| order_i | input | 1 | Burst order at load: 0 wrapping increment, 1 XOR |
| byte_we_i | input | LANES | Per-lane write enables, sampled with the command |
| wdata_i | input | DATA_W | Write data, one cycle after its command |
| oe_i | input | 1 | Output enable; low forces `rdata_o` to zero |
| rdata_o | output | DATA_W | Flow-through read data |
| rvalid_o | output | 1 | High in the cycle a read result is presented |

## Verification
The bench uses an 18-bit word (two 9-bit lanes) over 64 words. It fills and reads back every address, which separates correct address decode from aliasing. It then alternates writes and reads to the same addresses on consecutive cycles, which exposes any turnaround gap or stale data. A sweep over all four lane masks shows which lanes store.

Bursts are started from eight base addresses in both orders and run to five beats, which distinguishes increment from XOR stepping and checks the counter wrap. Burst writes check that the direction is kept.

Further sequences cover deselect followed by continue, reads with the output disabled, and sleep windows. One sleep window interrupts a read burst. Another holds a pending write while write commands are presented and must be ignored.

// File: rtl/zsram_pkg.sv
package zsram_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_RD   = 2'b01,
        CMD_WR   = 2'b10,
        CMD_NEXT = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10
    } op_e;

    typedef struct packed {
        op_e        dir;
        logic [1:0] beat;
        logic [1:0] start;
        logic       interleave;
    } burst_t;

    localparam burst_t BURST_RESET = '{dir: OP_NONE, beat: 2'd0, start: 2'd0, interleave: 1'b0};

    function automatic int unsigned lane_bits(int unsigned width);
        return (width % 9 == 0) ? 9 : 8;
    endfunction

    function automatic logic [1:0] beat_offset(logic [1:0] start, logic [1:0] beat, logic interleave);
        logic [1:0] sum;
        sum = start + beat;
        return interleave ? (start ^ beat) : sum;
    endfunction

endpackage

// File: rtl/zsram_seq.sv
module zsram_seq import zsram_pkg::*; #(
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned HI_W  = ADDR_W - 2
) (
    input  logic [1:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              order_i,
    input  burst_t            burst_q,
    input  logic [HI_W-1:0]   base_hi_q,
    output op_e               op_d,
    output logic [ADDR_W-1:0] addr_d,
    output burst_t            burst_d,
    output logic [HI_W-1:0]   base_hi_d
);

    logic [1:0] beat_nx;

    assign beat_nx = 2'(burst_q.beat + 2'd1);

    always_comb begin
        op_d      = OP_NONE;
        addr_d    = '0;
        burst_d   = burst_q;
        base_hi_d = base_hi_q;
        case (cmd_e'(cmd_i))
            CMD_IDLE: begin
                burst_d.dir = OP_NONE;
            end
            CMD_RD, CMD_WR: begin
                op_d      = (cmd_e'(cmd_i) == CMD_RD) ? OP_READ : OP_WRITE;
                addr_d    = addr_i;
                base_hi_d = addr_i[ADDR_W-1:2];
                burst_d   = '{dir: op_d, beat: 2'd0, start: addr_i[1:0], interleave: order_i};
            end
            CMD_NEXT: begin
                if (burst_q.dir != OP_NONE) begin
                    burst_d.beat = beat_nx;
                    op_d         = burst_q.dir;
                    addr_d       = {base_hi_q, beat_offset(burst_q.start, beat_nx, burst_q.interleave)};
                end
            end
            default: begin
                op_d = OP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/zsram_pipe.sv
module zsram_pipe import zsram_pkg::*; #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANES  = 4,
    localparam int unsigned HI_W  = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  op_e               op_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [LANES-1:0]  be_d,
    input  burst_t            burst_d,
    input  logic [HI_W-1:0]   base_hi_d,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  be_q,
    output burst_t            burst_q,
    output logic [HI_W-1:0]   base_hi_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= OP_NONE;
            addr_q    <= '0;
            be_q      <= '0;
            burst_q   <= BURST_RESET;
            base_hi_q <= '0;
        end else if (!hold) begin
            op_q      <= op_d;
            addr_q    <= addr_d;
            be_q      <= be_d;
            burst_q   <= burst_d;
            base_hi_q <= base_hi_d;
        end
    end

endmodule

// File: rtl/zsram_array.sv
module zsram_array #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned LANE_W = 9,
    localparam int unsigned LANES = DATA_W / LANE_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wbe,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wbe[l]) begin
                    mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
                end
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/zsram_ft.sv
module zsram_ft import zsram_pkg::*; #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned LANE_W = lane_bits(DATA_W),
    localparam int unsigned LANES  = DATA_W / LANE_W,
    localparam int unsigned HI_W   = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_i,
    input  logic [1:0]        cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              order_i,
    input  logic [LANES-1:0]  byte_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              oe_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    op_e               op_d, op_q;
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [LANES-1:0]  be_q;
    burst_t            burst_d, burst_q;
    logic [HI_W-1:0]   base_hi_d, base_hi_q;
    logic [DATA_W-1:0] arr_rdata;
    logic              commit;
    logic              read_live;

    zsram_seq #(.ADDR_W(ADDR_W)) i_seq (
        .cmd_i     (cmd_i),
        .addr_i    (addr_i),
        .order_i   (order_i),
        .burst_q   (burst_q),
        .base_hi_q (base_hi_q),
        .op_d      (op_d),
        .addr_d    (addr_d),
        .burst_d   (burst_d),
        .base_hi_d (base_hi_d)
    );

    zsram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) i_pipe (
        .clk       (clk),
        .rst       (rst),
        .hold      (sleep_i),
        .op_d      (op_d),
        .addr_d    (addr_d),
        .be_d      (byte_we_i),
        .burst_d   (burst_d),
        .base_hi_d (base_hi_d),
        .op_q      (op_q),
        .addr_q    (addr_q),
        .be_q      (be_q),
        .burst_q   (burst_q),
        .base_hi_q (base_hi_q)
    );

    assign commit    = (op_q == OP_WRITE) && !sleep_i && !rst;
    assign read_live = (op_q == OP_READ) && !sleep_i;

    zsram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_array (
        .clk   (clk),
        .we    (commit),
        .waddr (addr_q),
        .wbe   (be_q),
        .wdata (wdata_i),
        .raddr (addr_q),
        .rdata (arr_rdata)
    );

    assign rvalid_o = read_live;
    assign rdata_o  = (read_live && oe_i) ? arr_rdata : '0;

endmodule

// File: rtl/zsram_chk.sv
module zsram_chk import zsram_pkg::*; #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sleep_i,
    input logic [1:0]        cmd_i,
    input logic              oe_i,
    input logic              rvalid_o,
    input logic [DATA_W-1:0] rdata_o,
    input op_e               op_q,
    input logic [ADDR_W-1:0] addr_q,
    input burst_t            burst_q
);

    AST_READ_PRESENTED: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && cmd_i == 2'b01) |=> (rvalid_o || sleep_i)); // R2

    AST_WRITE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && cmd_i == 2'b10) |=> (!rvalid_o && rdata_o == '0)); // R3

    AST_BURST_SAME_GROUP: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && cmd_i == 2'b11 && burst_q.dir != OP_NONE)
        |=> (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))); // R5

    AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!sleep_i && cmd_i == 2'b00) |=> (!rvalid_o && rdata_o == '0)); // R8

    AST_OE_GATES: assert property (@(posedge clk) disable iff (rst)
        !oe_i |-> (rdata_o == '0)); // R9

    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        sleep_i |=> ($stable(addr_q) && $stable(op_q) && $stable(burst_q))); // R10

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep_i |-> !rvalid_o); // R10

endmodule

bind zsram_ft zsram_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .sleep_i  (sleep_i),
    .cmd_i    (cmd_i),
    .oe_i     (oe_i),
    .rvalid_o (rvalid_o),
    .rdata_o  (rdata_o),
    .op_q     (op_q),
    .addr_q   (addr_q),
    .burst_q  (burst_q)
);

// File: tb/test_zsram_ft.sv
module test_zsram_ft;
    import zsram_pkg::*;

    localparam int DW = 18;
    localparam int AW = 6;
    localparam int NW = 64;
    localparam int LW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_i = 1'b0;
    logic [1:0]    cmd_i = 2'b00;
    logic [AW-1:0] addr_i = '0;
    logic          order_i = 1'b0;
    logic [1:0]    byte_we_i = 2'b00;
    logic [DW-1:0] wdata_i = '0;
    logic          oe_i = 1'b1;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o;

    always #10 clk = ~clk;

    zsram_ft #(.DATA_W(DW), .ADDR_W(AW)) i_zsram_ft (
        .clk(clk), .rst(rst), .sleep_i(sleep_i), .cmd_i(cmd_i), .addr_i(addr_i),
        .order_i(order_i), .byte_we_i(byte_we_i), .wdata_i(wdata_i), .oe_i(oe_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    int total = 0;
    int bad = 0;
    int salt = 0;
    bit done = 1'b0;

    logic [DW-1:0]   ref_mem [NW];
    op_e             m_op = OP_NONE;
    op_e             m_dir = OP_NONE;
    logic [AW-1:0]   m_addr = '0;
    logic [1:0]      m_be = '0;
    logic [1:0]      m_beat = '0;
    logic [1:0]      m_start = '0;
    logic            m_ord = 1'b0;
    logic [AW-3:0]   m_hi = '0;

    function automatic logic [DW-1:0] mkdata(logic [AW-1:0] a, int s);
        int v;
        v = int'(a) * 37 + s * 1013 + 5 + (s << 13);
        return v[DW-1:0];
    endfunction

    task automatic step(input logic [1:0] cmd, input logic [AW-1:0] a, input logic ord,
                        input logic [1:0] be, input logic oe, input logic slp, input string req);
        logic [DW-1:0] wd;
        logic [DW-1:0] exp_d;
        logic          exp_v;
        @(negedge clk);
        cmd_i = cmd; addr_i = a; order_i = ord; byte_we_i = be; oe_i = oe; sleep_i = slp;
        wd = (m_op == OP_WRITE) ? mkdata(m_addr, salt) : ~mkdata(a, salt + 7);
        wdata_i = wd;
        #1;
        exp_v = !slp && (m_op == OP_READ);
        exp_d = (exp_v && oe) ? ref_mem[m_addr] : '0;
        total++;
        if (rvalid_o !== exp_v || rdata_o !== exp_d) begin
            bad++;
            $display("FAIL %s valid=%b data=%h expected valid=%b data=%h", req, rvalid_o, rdata_o, exp_v, exp_d);
        end
        @(posedge clk);
        if (!slp) begin
            if (m_op == OP_WRITE) begin
                for (int l = 0; l < 2; l++) begin
                    if (m_be[l]) ref_mem[m_addr][l*LW +: LW] = wd[l*LW +: LW];
                end
            end
            case (cmd)
                2'b00: begin m_op = OP_NONE; m_dir = OP_NONE; end
                2'b01, 2'b10: begin
                    m_op = (cmd == 2'b01) ? OP_READ : OP_WRITE;
                    m_dir = m_op; m_addr = a; m_be = be; m_hi = a[AW-1:2];
                    m_start = a[1:0]; m_beat = 2'd0; m_ord = ord;
                end
                default: begin
                    if (m_dir == OP_NONE) begin
                        m_op = OP_NONE;
                    end else begin
                        m_beat = m_beat + 2'd1;
                        m_op = m_dir; m_be = be;
                        m_addr = {m_hi, m_ord ? (m_start ^ m_beat) : 2'(m_start + m_beat)};
                    end
                end
            endcase
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        total++;
        if (rvalid_o !== 1'b0 || rdata_o !== '0) begin
            bad++;
            $display("FAIL R1 reset valid=%b data=%h expected valid=0 data=0", rvalid_o, rdata_o);
        end
        // R1: continue before any load acts as deselect
        step(2'b11, 6'd5, 1'b0, 2'b11, 1'b1, 1'b0, "R1");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R1");

        // R3 fill every word, R2 read every word back
        salt = 1;
        for (int a = 0; a < NW; a++) step(2'b10, 6'(a), 1'b0, 2'b11, 1'b1, 1'b0, "R3");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R3");
        for (int a = 0; a < NW; a++) step(2'b01, 6'(a), 1'b0, 2'b00, 1'b1, 1'b0, "R2");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R2");

        // R4 write then read on back-to-back cycles
        salt = 2;
        for (int a = 0; a < NW; a += 3) begin
            step(2'b10, 6'(a), 1'b0, 2'b11, 1'b1, 1'b0, "R4");
            step(2'b01, 6'(a), 1'b0, 2'b00, 1'b1, 1'b0, "R4");
        end
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R4");

        // R3 lane mask sweep
        salt = 3;
        for (int a = 0; a < 16; a++) begin
            step(2'b10, 6'(a), 1'b0, 2'(a), 1'b1, 1'b0, "R3");
            step(2'b01, 6'(a), 1'b0, 2'b00, 1'b1, 1'b0, "R3");
        end
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R3");

        // R5 / R6 read bursts, five beats for R7 wrap
        for (int s = 0; s < 8; s++) begin
            for (int o = 0; o < 2; o++) begin
                step(2'b01, 6'(s * 5), 1'(o), 2'b00, 1'b1, 1'b0, "R7");
                for (int b = 0; b < 4; b++)
                    step(2'b11, 6'd63, 1'(1 - o), 2'b00, 1'b1, 1'b0, (o == 0) ? "R5" : "R6");
            end
        end
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R7");

        // R7 write bursts keep direction, then read the group back
        salt = 4;
        for (int s = 0; s < 3; s++) begin
            for (int o = 0; o < 2; o++) begin
                step(2'b10, 6'(s * 9 + 1), 1'(o), 2'b11, 1'b1, 1'b0, "R7");
                for (int b = 0; b < 3; b++) step(2'b11, 6'd0, 1'b0, 2'(b + 1), 1'b1, 1'b0, "R7");
                step(2'b01, 6'(s * 9 + 1), 1'(o), 2'b00, 1'b1, 1'b0, "R7");
                for (int b = 0; b < 3; b++) step(2'b11, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R7");
            end
        end
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R7");

        // R9 output enable toggling on live reads
        for (int a = 0; a < 8; a++) step(2'b01, 6'(a + 40), 1'b0, 2'b00, 1'(a % 2), 1'b0, "R9");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b0, 1'b0, "R9");

        // R8 deselect cancels burst
        step(2'b01, 6'd3, 1'b0, 2'b00, 1'b1, 1'b0, "R8");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R8");
        step(2'b11, 6'd0, 1'b0, 2'b11, 1'b1, 1'b0, "R8");
        step(2'b11, 6'd0, 1'b0, 2'b11, 1'b1, 1'b0, "R8");
        step(2'b01, 6'd4, 1'b0, 2'b00, 1'b1, 1'b0, "R8");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R8");

        // R10 sleep inside a read burst, ignored writes while asleep
        salt = 5;
        step(2'b01, 6'd8, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b11, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        for (int i = 0; i < 3; i++) step(2'b10, 6'd20, 1'b0, 2'b11, 1'b1, 1'b1, "R10");
        step(2'b11, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b11, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        // R10 pending write held across sleep
        salt = 6;
        step(2'b10, 6'd30, 1'b0, 2'b11, 1'b1, 1'b0, "R10");
        step(2'b10, 6'd31, 1'b0, 2'b11, 1'b1, 1'b1, "R10");
        step(2'b10, 6'd31, 1'b0, 2'b11, 1'b1, 1'b1, "R10");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b01, 6'd30, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b01, 6'd20, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b01, 6'd31, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R10");
        step(2'b00, 6'd0, 1'b0, 2'b00, 1'b1, 1'b0, "R8");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule